// File: doc/BRIEF.md
# Channel clock blocking generator

This block produces per-timeslot gating outputs for a framed serial link carrying 32 eight-bit timeslots per frame, separately for the receive and the transmit direction. Each direction owns a 32-bit channel bitmap, loaded through a byte-wide write port as four bytes. While the timeslot whose bitmap bit is 1 is on the line, the blocking output of that direction stays high for all eight bits. Downstream HDLC or USART logic can then take in only the selected channels and ignore the rest.

The transmit bitmap has a second use. When the alternate-mode control bit is set, the transmit bitmap no longer gates the transmit blocking output, which is held low. The bitmap drives a signaling-source select output instead. A 1 on that output means the channel's signaling bits come from internal signaling storage. A 0 means they come from the external serial inputs. The insertion of signaling bits is done elsewhere.

Both directions run from one system clock. Each direction has its own bit-rate strobe and frame sync, and its own timeslot and bit counters. The frame sync forces the next bit to be bit 0 of timeslot 0. Outputs are registered, and they change only on the strobe that begins a timeslot.

Top module: `chan_block_gen`

## Requirements
- R1: After reset, `rx_blk`, `tx_blk` and `tx_sig_sel` are 0, both bitmaps are all zero and the alternate mode is off.
- R2: A write with `wr_addr` 0..3 loads receive byte n, and `wr_addr` 4..7 loads transmit byte n-4. In every bitmap byte, bit b of byte n belongs to timeslot index 8n+b, so index 0 is channel 1 and index 31 is channel 32. A write to `wr_addr` 8 loads the alternate-mode bit from `wr_data[0]`. Writes to any other address change nothing.
- R3: On each `rx_bit_en` strobe that begins bit 0 of a timeslot, `rx_blk` takes that timeslot's receive bitmap bit, using the bitmap as it stood before that edge. It then holds that value until the next timeslot begins.
- R4: A `rx_bit_en` or `tx_bit_en` strobe with the matching frame sync high makes that strobe bit 0 of timeslot 0, whatever the counters held.
- R5: Without frame sync, every 8 bit strobes advance one timeslot, and timeslot 31 wraps to timeslot 0.
- R6: With the alternate mode off, `tx_blk` follows the transmit bitmap with the same timing as R3, using `tx_bit_en`, and `tx_sig_sel` is 0 at every timeslot start.
- R7: With the alternate mode on at a transmit timeslot start, `tx_blk` is 0 and `tx_sig_sel` takes the transmit bitmap bit (1 = internal signaling storage, 0 = external serial input).
- R8: The receive bitmap affects only `rx_blk`, and the transmit bitmap and mode affect only `tx_blk` and `tx_sig_sel`.
- R9: A bitmap or mode write during a timeslot leaves the outputs unchanged until the next timeslot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| rx_bit_en | input | 1 | Receive bit-rate strobe |
| rx_fsync | input | 1 | Receive frame sync, sampled with `rx_bit_en` |
| tx_bit_en | input | 1 | Transmit bit-rate strobe |
| tx_fsync | input | 1 | Transmit frame sync, sampled with `tx_bit_en` |
| rx_blk | output | 1 | Receive channel blocking output |
| tx_blk | output | 1 | Transmit channel blocking output |
| tx_sig_sel | output | 1 | Signaling source select, 1 = internal |

## Verification
A counter that is off by one bit or one timeslot shows as a blocking pulse displaced along the frame. Bitmaps with uneven patterns make this a miscompare within one timeslot of the error. A misrouted bitmap byte or a swapped bit order appears the first time the affected timeslot comes round, so within one frame of 256 strobes. A mode bit latched in the wrong place shows on the transmit pair at the next transmit timeslot start. An output updated mid-slot breaks the 8-strobe hold on the very next strobe.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int CBG_SLOTS    = 32;
  localparam int CBG_SLOTBITS = 8;
  localparam int CBG_REGW     = 8;
  localparam int CBG_ADDRW    = 4;

  // register index of a write address within one bitmap, or -1 when outside
  function automatic int map_byte(input int addr, input int base, input int nreg);
    if (addr >= base && addr < base + nreg) return addr - base;
    return -1;
  endfunction

  // modular increment used by the slot counter
  function automatic int wrap_inc(input int v, input int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/cbg_regs.sv
module cbg_regs
  import cbg_pkg::*;
#(
  parameter int NUM_SLOTS = CBG_SLOTS,
  parameter int REG_W     = CBG_REGW,
  parameter int ADDR_W    = CBG_ADDRW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [NUM_SLOTS-1:0] rx_map,
  output logic [NUM_SLOTS-1:0] tx_map,
  output logic                 alt_mode
);
  localparam int NREG      = NUM_SLOTS / REG_W;
  localparam int CTRL_ADDR = 2 * NREG;

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_map[g*REG_W +: REG_W] <= '0;
        tx_map[g*REG_W +: REG_W] <= '0;
      end else if (wr_en) begin
        if (map_byte(int'(wr_addr), 0, NREG) == g)
          rx_map[g*REG_W +: REG_W] <= wr_data;
        if (map_byte(int'(wr_addr), NREG, NREG) == g)
          tx_map[g*REG_W +: REG_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      alt_mode <= 1'b0;
    else if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)))
      alt_mode <= wr_data[0];
  end
endmodule

// File: rtl/cbg_slot_timer.sv
module cbg_slot_timer
  import cbg_pkg::*;
#(
  parameter int NUM_SLOTS = CBG_SLOTS,
  parameter int SLOT_BITS = CBG_SLOTBITS,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          fsync,
  output logic          slot_start,
  output logic [SW-1:0] next_slot
);
  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic [BW-1:0] next_bit;

  always_comb begin
    if (fsync) begin
      next_bit  = '0;
      next_slot = '0;
    end else if (bit_q == BW'(SLOT_BITS - 1)) begin
      next_bit  = '0;
      next_slot = SW'(wrap_inc(int'(slot_q), NUM_SLOTS));
    end else begin
      next_bit  = bit_q + 1'b1;
      next_slot = slot_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else if (bit_en) begin
      slot_q <= next_slot;
      bit_q  <= next_bit;
    end
  end

  assign slot_start = bit_en && (next_bit == '0);
endmodule

// File: rtl/cbg_gate.sv
module cbg_gate
  import cbg_pkg::*;
#(
  parameter int NUM_SLOTS = CBG_SLOTS,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 enable,
  input  logic [SW-1:0]        slot,
  input  logic [NUM_SLOTS-1:0] map,
  output logic                 q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= 1'b0;
    else if (load)
      q <= enable & map[slot];
  end
endmodule

// File: rtl/chan_block_gen.sv
module chan_block_gen
  import cbg_pkg::*;
#(
  parameter int NUM_SLOTS = CBG_SLOTS,
  parameter int SLOT_BITS = CBG_SLOTBITS,
  parameter int REG_W     = CBG_REGW,
  parameter int ADDR_W    = CBG_ADDRW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rx_bit_en,
  input  logic              rx_fsync,
  input  logic              tx_bit_en,
  input  logic              tx_fsync,
  output logic              rx_blk,
  output logic              tx_blk,
  output logic              tx_sig_sel
);
  localparam int SW = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] rx_map, tx_map;
  logic                 alt_mode;
  logic                 rx_start, tx_start;
  logic [SW-1:0]        rx_slot, tx_slot;

  cbg_regs #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_map(rx_map), .tx_map(tx_map), .alt_mode(alt_mode)
  );

  cbg_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_rx_tmr (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .fsync(rx_fsync),
    .slot_start(rx_start), .next_slot(rx_slot)
  );

  cbg_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_tx_tmr (
    .clk(clk), .rst_n(rst_n), .bit_en(tx_bit_en), .fsync(tx_fsync),
    .slot_start(tx_start), .next_slot(tx_slot)
  );

  cbg_gate #(.NUM_SLOTS(NUM_SLOTS)) u_rx_gate (
    .clk(clk), .rst_n(rst_n), .load(rx_start), .enable(1'b1),
    .slot(rx_slot), .map(rx_map), .q(rx_blk)
  );

  cbg_gate #(.NUM_SLOTS(NUM_SLOTS)) u_tx_gate (
    .clk(clk), .rst_n(rst_n), .load(tx_start), .enable(!alt_mode),
    .slot(tx_slot), .map(tx_map), .q(tx_blk)
  );

  cbg_gate #(.NUM_SLOTS(NUM_SLOTS)) u_sel_gate (
    .clk(clk), .rst_n(rst_n), .load(tx_start), .enable(alt_mode),
    .slot(tx_slot), .map(tx_map), .q(tx_sig_sel)
  );
endmodule

// File: rtl/cbg_checker.sv
module cbg_checker #(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_bit_en,
  input logic                 rx_fsync,
  input logic                 rx_start,
  input logic                 tx_start,
  input logic                 alt_mode,
  input logic [NUM_SLOTS-1:0] rx_map,
  input logic                 rx_blk,
  input logic                 tx_blk,
  input logic                 tx_sig_sel
);
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_start) |-> $stable(rx_blk)); // R3

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_start) |-> ($stable(tx_blk) && $stable(tx_sig_sel))); // R9

  AST_FSYNC_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_bit_en && rx_fsync) |-> (rx_blk == $past(rx_map[0]))); // R4

  AST_ALT_TX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_start) && $past(alt_mode)) |-> !tx_blk); // R7

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_start) && !$past(alt_mode)) |-> !tx_sig_sel); // R6

  AST_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_blk && tx_sig_sel)); // R8
endmodule

bind chan_block_gen cbg_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_fsync(rx_fsync),
  .rx_start(rx_start), .tx_start(tx_start), .alt_mode(alt_mode),
  .rx_map(rx_map), .rx_blk(rx_blk), .tx_blk(tx_blk), .tx_sig_sel(tx_sig_sel)
);

// File: tb/chan_block_gen_test.sv
`timescale 1ns/1ps
module chan_block_gen_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rx_bit_en = 1'b0, rx_fsync = 1'b0;
  logic       tx_bit_en = 1'b0, tx_fsync = 1'b0;
  logic       rx_blk, tx_blk, tx_sig_sel;

  chan_block_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_bit_en(rx_bit_en), .rx_fsync(rx_fsync), .tx_bit_en(tx_bit_en), .tx_fsync(tx_fsync),
    .rx_blk(rx_blk), .tx_blk(tx_blk), .tx_sig_sel(tx_sig_sel)
  );

  int    vectors = 0, fails = 0;
  string phase = "R1";
  bit    comparing = 1'b0;

  // behavioural reference
  bit [31:0] m_rx, m_tx;
  bit        m_mode;
  int        rs, rb, ts, tb;
  bit        e_rx, e_tx, e_sel;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; m_mode = 0;
      rs = 0; rb = 0; ts = 0; tb = 0;
      e_rx = 0; e_tx = 0; e_sel = 0;
    end else begin
      if (rx_bit_en) begin
        if (rx_fsync) begin rs = 0; rb = 0; end
        else begin
          rb = rb + 1;
          if (rb == 8) begin rb = 0; rs = (rs + 1) % 32; end
        end
        if (rb == 0) e_rx = m_rx[rs];
      end
      if (tx_bit_en) begin
        if (tx_fsync) begin ts = 0; tb = 0; end
        else begin
          tb = tb + 1;
          if (tb == 8) begin tb = 0; ts = (ts + 1) % 32; end
        end
        if (tb == 0) begin
          e_tx  = m_mode ? 1'b0 : m_tx[ts];
          e_sel = m_mode ? m_tx[ts] : 1'b0;
        end
      end
      if (wr_en) begin
        if (wr_addr < 4)       m_rx[wr_addr*8 +: 8] = wr_data;
        else if (wr_addr < 8)  m_tx[(wr_addr-4)*8 +: 8] = wr_data;
        else if (wr_addr == 8) m_mode = wr_data[0];
      end
    end
  end

  task automatic check(input string tag, input string name, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      check(phase, "rx_blk", rx_blk, e_rx);
      check(m_mode ? "R7" : "R6", "tx_blk", tx_blk, e_tx);
      check(m_mode ? "R7" : "R6", "tx_sig_sel", tx_sig_sel, e_sel);
    end
  end

  int  rx_cnt = 0, tx_cnt = 0;
  bit  ph = 1'b0;
  bit  fs_on = 1'b1;

  task automatic step(input bit we, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    rx_bit_en = 1'b1;
    rx_fsync  = fs_on && (rx_cnt % 256 == 0);
    rx_cnt++;
    tx_bit_en = ph;
    tx_fsync  = ph && fs_on && (tx_cnt % 256 == 0);
    if (ph) tx_cnt++;
    ph = ~ph;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 8'd0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with no strobes
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", "rx_blk", rx_blk, 1'b0);
      check("R1", "tx_blk", tx_blk, 1'b0);
      check("R1", "tx_sig_sel", tx_sig_sel, 1'b0);
    end
    comparing = 1'b1;
    // R1: empty bitmaps keep outputs low while counting
    run(300);
    phase = "R2";
    step(1, 4'd0, 8'hA5); step(1, 4'd1, 8'h3C);
    step(1, 4'd2, 8'h0F); step(1, 4'd3, 8'h81);
    step(1, 4'd4, 8'h5A); step(1, 4'd5, 8'hC3);
    step(1, 4'd6, 8'hF0); step(1, 4'd7, 8'h18);
    step(1, 4'd9, 8'hFF); step(1, 4'd15, 8'hFF);
    phase = "R3";
    rx_cnt = 0; tx_cnt = 0;
    run(1100);
    phase = "R4";
    rx_cnt = 0; run(77);
    tx_cnt = 0; run(600);
    phase = "R5";
    fs_on = 1'b0;
    run(1200);
    fs_on = 1'b1;
    phase = "R9";
    for (int k = 0; k < 24; k++) begin
      step(1, 4'(k % 8), 8'((k * 73 + 29) % 256));
      run(37 + k);
    end
    phase = "R8";
    step(1, 4'd0, 8'hFF); step(1, 4'd2, 8'h00);
    run(600);
    phase = "R7";
    step(1, 4'd8, 8'h01);
    run(700);
    step(1, 4'd4, 8'h96); step(1, 4'd7, 8'h69);
    run(700);
    phase = "R6";
    step(1, 4'd8, 8'h00);
    run(700);
    comparing = 1'b0;
    summary();
  end
endmodule